// File: doc/BRIEF.md
# Per-Pin Change Interrupt Controller

This block watches a port of N asynchronous input pins and records, for each pin, a sticky flag whenever that pin makes a transition of a polarity software has selected. Each pin carries two separate selections, one for low-to-high and one for high-to-low transitions, so a pin can report one polarity, the other, both, or nothing. The flags are OR-ed into a summary bit. A master switch decides whether a pending flag raises the interrupt line, but it never stops transitions from being recorded.

Software reaches the block through a synchronous write port, where a two-bit select picks one of four registers, and reads the flag vector and summary directly. A transition detected in the same cycle as a flag write always survives that write. So clearing with a read-modify-write that writes zero only to bits already seen cannot lose an event. While the surrounding system is in a low-power state, a recorded transition with the master switch on raises a one-cycle wake request. The matching flag is already visible when that request appears.

Top module: `pin_change_irq`

## Requirements
- R1: Each pin is resynchronised through two flops. A level change first sampled at rising clock edge k sets its flag at edge k+2, and not earlier.
- R2: With only the rise-select bit of a pin set (register select 0), a low-to-high transition sets the pin's flag and a high-to-low transition does not.
- R3: With only the fall-select bit of a pin set (register select 1), a high-to-low transition sets the pin's flag and a low-to-high transition does not. A flag never changes except through a flag write or a selected transition.
- R4: With both select bits of a pin set, either transition sets its flag.
- R5: A set flag stays set, whatever the pin does, until a flag write clears it.
- R6: With the master switch off (bit 0 of register select 3 clear), transitions still set flags but `irq_o` stays low.
- R7: `irq_o` goes high on the clock edge after one on which the master switch is on and at least one flag is set.
- R8: `summary_o` is high exactly when any bit of `flags_o` is high.
- R9: A write to register select 2 loads the flag vector: a 0 bit clears that flag and a 1 bit sets it.
- R10: If a selected transition on a pin is detected in the same cycle as a flag write, that pin's flag is set after the write, whatever value was written to it.
- R11: While `sleep_i` is high and the master switch is on, a detected selected transition raises `wake_o` for exactly one cycle, on the same edge that sets its flag. No wake request appears with the master switch off or with `sleep_i` low.
- R12: After reset all select bits, the master switch and all flags are zero, and `irq_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | N | Asynchronous pins being watched |
| sleep_i | input | 1 | High while the system is in its low-power state |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 rise selects, 1 fall selects, 2 flags, 3 control |
| wr_data_i | input | N | Write data; for the control register only bit 0 is used |
| flags_o | output | N | Per-pin sticky flags |
| summary_o | output | 1 | OR of all flags |
| irq_o | output | 1 | Registered interrupt request |
| wake_o | output | 1 | One-cycle wake request during the low-power state |

## Verification
On every cycle, the assertions check that flags only rise through a write or a detected transition and otherwise hold. They also check that a detected transition is never lost to a simultaneous write, that the interrupt line follows the master switch and the flags with one cycle of delay, and that each wake request comes with sleep, the master switch and a pending flag. Only the bench scenarios can show the latency through the synchroniser, the polarity selection per pin, and the exact clearing and setting effect of written values. The same holds for the one-cycle length of a wake pulse and its absence when the system is awake or the switch is off.

// File: rtl/ioc_pkg.sv
`timescale 1ns/1ps
// Package: shared register selects and control field positions for the
// pin change interrupt controller. Assumes a two-bit register select.
package ioc_pkg;

    typedef enum logic [1:0] {
        SEL_RISE = 2'd0,
        SEL_FALL = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    localparam int CTRL_MASTER_BIT = 0;

endpackage

// File: rtl/ioc_pin_sync.sv
`timescale 1ns/1ps
// Module: ioc_pin_sync
// Brings N asynchronous pins into the clock domain through a chain of
// STAGES flops, and keeps one more copy delayed by a cycle so that a
// neighbour can compare the current and previous level.
// Assumes STAGES >= 2 and that the pins are low during reset.
module ioc_pin_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o
);
    localparam int LAST = STAGES - 1;

    logic [N-1:0] stage_q [STAGES];
    logic [N-1:0] prev_q;

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pins_i;
    end

    // Remaining stages shift the sampled level along the chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    // Previous-cycle copy of the synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[LAST];
    end

    assign cur_o  = stage_q[LAST];
    assign prev_o = prev_q;

endmodule

// File: rtl/ioc_edge_detect.sv
`timescale 1ns/1ps
// Module: ioc_edge_detect
// Compares the synchronised level of each pin with its previous value
// and reports a hit where the transition polarity is selected.
// Assumes cur and prev come from the same synchroniser chain.
module ioc_edge_detect #(
    parameter int N = 8
) (
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] rise_sel_i,
    input  logic [N-1:0] fall_sel_i,
    output logic [N-1:0] hit_o
);
    // Per-pin polarity match, one slice per pin.
    for (genvar p = 0; p < N; p++) begin : g_pin
        logic went_up;
        logic went_down;
        // Classify the transition seen on this pin.
        always_comb begin
            went_up   = cur_i[p] & ~prev_i[p];
            went_down = ~cur_i[p] & prev_i[p];
            hit_o[p]  = (went_up & rise_sel_i[p]) | (went_down & fall_sel_i[p]);
        end
    end

endmodule

// File: rtl/ioc_regs.sv
`timescale 1ns/1ps
// Module: ioc_regs
// Holds the software-written state: rise selects, fall selects, the
// master switch and the sticky flags. Detected hits are OR-ed into the
// flag vector after any write, so a hit always survives a write.
// Assumes wr_sel_i uses the encodings of ioc_pkg.
module ioc_regs
    import ioc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [1:0]   wr_sel_i,
    input  logic [N-1:0] wr_data_i,
    input  logic [N-1:0] hit_i,
    output logic [N-1:0] rise_sel_o,
    output logic [N-1:0] fall_sel_o,
    output logic         master_o,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] rise_q, fall_q, flag_q, flag_d;
    logic         master_q;
    logic         wr_rise, wr_fall, wr_flag, wr_ctrl;

    // Decode which register the current write targets.
    always_comb begin
        wr_rise = wr_en_i && (wr_sel_i == SEL_RISE);
        wr_fall = wr_en_i && (wr_sel_i == SEL_FALL);
        wr_flag = wr_en_i && (wr_sel_i == SEL_FLAG);
        wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
    end

    // Next flag value: written value or held value, then hits on top.
    always_comb begin
        flag_d = wr_flag ? wr_data_i : flag_q;
        flag_d = flag_d | hit_i;
    end

    // Polarity select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            if (wr_rise) rise_q <= wr_data_i;
            if (wr_fall) fall_q <= wr_data_i;
        end
    end

    // Master switch register.
    always_ff @(posedge clk) begin
        if (!rst_n)       master_q <= 1'b0;
        else if (wr_ctrl) master_q <= wr_data_i[CTRL_MASTER_BIT];
    end

    // Sticky flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign rise_sel_o = rise_q;
    assign fall_sel_o = fall_q;
    assign master_o   = master_q;
    assign flags_o    = flag_q;

endmodule

// File: rtl/ioc_irq_gen.sv
`timescale 1ns/1ps
// Module: ioc_irq_gen
// Forms the summary bit from the flags, registers the interrupt request
// gated by the master switch, and raises a one-cycle wake request when
// a hit arrives during the low-power state with the switch on.
// Assumes hits are the same-cycle inputs of the flag register.
module ioc_irq_gen #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] hit_i,
    input  logic         master_i,
    input  logic         sleep_i,
    output logic         summary_o,
    output logic         irq_o,
    output logic         wake_o
);
    logic irq_q, wake_q;

    // Summary is the reduction OR of the flags.
    assign summary_o = |flags_i;

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= summary_o & master_i;
    end

    // Registered wake pulse, aligned with the flag update of the hit.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= sleep_i & master_i & (|hit_i);
    end

    assign irq_o  = irq_q;
    assign wake_o = wake_q;

endmodule

// File: rtl/pin_change_irq.sv
`timescale 1ns/1ps
// Module: pin_change_irq (top)
// Per-pin change interrupt controller: synchroniser, polarity match,
// registers and interrupt/wake generation.
// Assumes a single clock and a synchronous active-low reset.
module pin_change_irq #(
    parameter int N          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    input  logic         sleep_i,
    input  logic         wr_en_i,
    input  logic [1:0]   wr_sel_i,
    input  logic [N-1:0] wr_data_i,
    output logic [N-1:0] flags_o,
    output logic         summary_o,
    output logic         irq_o,
    output logic         wake_o
);
    logic [N-1:0] pin_cur, pin_prev, edge_hit, rise_sel, fall_sel;
    logic         master_q;

    ioc_pin_sync #(.N(N), .STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    ioc_edge_detect #(.N(N)) u_edge (
        .cur_i      (pin_cur),
        .prev_i     (pin_prev),
        .rise_sel_i (rise_sel),
        .fall_sel_i (fall_sel),
        .hit_o      (edge_hit)
    );

    ioc_regs #(.N(N)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .hit_i      (edge_hit),
        .rise_sel_o (rise_sel),
        .fall_sel_o (fall_sel),
        .master_o   (master_q),
        .flags_o    (flags_o)
    );

    ioc_irq_gen #(.N(N)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_i   (flags_o),
        .hit_i     (edge_hit),
        .master_i  (master_q),
        .sleep_i   (sleep_i),
        .summary_o (summary_o),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

endmodule

// File: rtl/ioc_checker.sv
`timescale 1ns/1ps
// Module: ioc_checker
// Cycle-by-cycle properties of the pin change interrupt controller,
// bound into the top module.
module ioc_checker
    import ioc_pkg::*;
#(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic         sleep,
    input logic         master,
    input logic [N-1:0] hit,
    input logic [N-1:0] flags,
    input logic         irq,
    input logic         wake
);
    logic flag_wr;
    assign flag_wr = wr_en && (wr_sel == SEL_FLAG);

    // R5: without a flag write, no set flag drops.
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flags & $past(flags)) == $past(flags)));

    // R10: every detected hit is present after the edge, write or not.
    a_r10_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((flags & $past(hit)) == $past(hit)));

    // R3: no write and no hit leaves the flags unchanged.
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && (hit == '0)) |=> (flags == $past(flags)));

    // R6: switch off keeps the interrupt low on the next cycle.
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> !irq);

    // R7: switch on with a pending flag raises the interrupt next cycle.
    a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (master && (flags != '0)) |=> irq);

    // R11: a wake request needs sleep and the switch in the prior cycle.
    a_r11_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(sleep) && $past(master)));

    // R11: the flag behind a wake request is already visible.
    a_r11_wake_flag_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (flags != '0));

endmodule

bind pin_change_irq ioc_checker #(.N(N)) u_ioc_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en_i),
    .wr_sel (wr_sel_i),
    .sleep  (sleep_i),
    .master (master_q),
    .hit    (edge_hit),
    .flags  (flags_o),
    .irq    (irq_o),
    .wake   (wake_o)
);

// File: tb/pin_change_irq_bench.sv
`timescale 1ns/1ps
module pin_change_irq_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic         sleep = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] flags;
    logic         summary, irq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pin_change_irq #(.N(N)) u_pin_change_irq (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .sleep_i(sleep),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .flags_o(flags), .summary_o(summary), .irq_o(irq), .wake_o(wake)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // One register write, ending on the negedge after it took effect.
    task automatic wr(input logic [1:0] sel, input logic [N-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12", flags, 0, "flags after reset");
        check("R12", {summary, irq, wake}, 0, "outputs after reset");
    endtask

    task automatic t_rise_only();
        wr(2'd0, 8'h01);
        set_pins(8'h01);
        wait_neg(2);
        check("R1", flags, 8'h00, "flag before latency");
        wait_neg(1);
        check("R2", flags, 8'h01, "rise sets flag");
        wr(2'd2, 8'h00);
        set_pins(8'h00);
        wait_neg(4);
        check("R2", flags, 8'h00, "fall ignored with rise select");
        wr(2'd0, 8'h00);
    endtask

    task automatic t_fall_only();
        wr(2'd1, 8'h02);
        set_pins(8'h02);
        wait_neg(4);
        check("R3", flags, 8'h00, "rise ignored with fall select");
        set_pins(8'h00);
        wait_neg(3);
        check("R3", flags, 8'h02, "fall sets flag");
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_both();
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h04);
        set_pins(8'h04);
        wait_neg(3);
        check("R4", flags, 8'h04, "rise with both selects");
        wr(2'd2, 8'h00);
        set_pins(8'h00);
        wait_neg(3);
        check("R4", flags, 8'h04, "fall with both selects");
        wait_neg(10);
        check("R5", flags, 8'h04, "flag sticky while pin idle");
        wr(2'd2, 8'h00);
        check("R9", flags, 8'h00, "write zero clears");
        check("R8", summary, 0, "summary low with no flags");
    endtask

    task automatic t_master();
        set_pins(8'h04);
        wait_neg(3);
        check("R6", flags, 8'h04, "flag set with master off");
        check("R8", summary, 1, "summary follows flag");
        wait_neg(2);
        check("R6", irq, 0, "irq low with master off");
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7", irq, 0, "irq one cycle after master on");
        @(negedge clk);
        check("R7", irq, 1, "irq raised next cycle");
        wr(2'd2, 8'h00);
        @(negedge clk);
        check("R7", irq, 0, "irq drops after clear");
        set_pins(8'h00);
        wait_neg(4);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_write_one();
        wr(2'd2, 8'h80);
        check("R9", flags, 8'h80, "write one sets flag");
        @(negedge clk);
        check("R9", irq, 1, "irq from written flag");
        wr(2'd2, 8'h00);
    endtask

    task automatic t_edge_wins();
        wr(2'd2, 8'h80);
        set_pins(8'h04);
        wait_neg(2);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10", flags, 8'h04, "edge survives clearing write");
        wr(2'd2, 8'h00);
        set_pins(8'h00);
        wait_neg(4);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_wake();
        sleep = 1'b1;
        set_pins(8'h04);
        wait_neg(2);
        check("R11", wake, 0, "no wake before flag");
        @(negedge clk);
        check("R11", wake, 1, "wake pulse on hit");
        check("R11", flags, 8'h04, "flag visible with wake");
        @(negedge clk);
        check("R11", wake, 0, "wake lasts one cycle");
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        set_pins(8'h00);
        wait_neg(3);
        check("R11", wake, 0, "no wake with master off");
        check("R11", flags, 8'h04, "flag still set with master off");
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        sleep = 1'b0;
        set_pins(8'h04);
        wait_neg(3);
        check("R11", wake, 0, "no wake while awake");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rise_only();
        t_fall_only();
        t_both();
        t_master();
        t_write_one();
        t_edge_wins();
        t_wake();
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
            $finish;
        end
    end

endmodule